// File: doc/BRIEF.md
# Master Configuration Clock Generator

This block makes the configuration clock a device drives out while it loads its own configuration from a serial source. It divides a free-running internal oscillator. After reset the output always runs at the slowest rate. Part way through the load, the loader decodes a rate code from the incoming configuration data and hands it to this block through a code input and a one-cycle load strobe. The new rate starts at the next whole-period boundary, so the outgoing clock never shows a shortened high or low phase.

Alongside the pin-level clock, the block gives the serial loader two single-cycle strobes in the oscillator domain. One marks the first oscillator cycle in which the outgoing clock is high; the loader captures serial data on it. The other marks the first oscillator cycle in which the clock is low; the loader launches daisy-chain data on it. When the load completes, a done input parks the clock low. A clock that is high at that moment finishes its high phase at full width before it parks.

Top module: `cfgclk_master_gen`

## Requirements
- R1: While reset is asserted and after it is released, `cclk_out`, `rise_stb` and `fall_stb` are 0. The first periods after reset use the rate of code 0: high and low phases of SLOW_HALF (default 32) oscillator cycles each.
- R2: A rate code c on the 4-bit `sel_code` gives high and low phases of max(1, SLOW_HALF >> c) oscillator cycles each. With the default, codes 0..4 give 32, 16, 8, 4 and 2, and codes 5..15 give 1.
- R3: A code captured by `sel_load` takes effect only after the next falling edge of `cclk_out`. The period in progress (its low phase and then its high phase) finishes at the old rate. Within any one period, the high phase is exactly as long as the low phase before it.
- R4: If several codes are loaded before a period boundary, only the last one takes effect at that boundary.
- R5: `rise_stb` is 1 for exactly the first oscillator cycle in which `cclk_out` is 1. `fall_stb` is 1 for exactly the first oscillator cycle in which `cclk_out` is 0 after a high phase. The two are never 1 together, and `cclk_out` never changes without one of them.
- R6: If `done` is asserted while `cclk_out` is high, the high phase runs to its full width. `cclk_out` then falls and stays 0, with no further strobes, until reset.
- R7: If `done` is asserted while `cclk_out` is low, no further rising edge occurs. `cclk_out` stays 0 with no strobes until reset.
- R8: A reset applied mid-run, after a faster code was loaded, brings the block back to the code 0 rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_code | input | 4 | Rate code decoded from the configuration data |
| sel_load | input | 1 | One-cycle strobe that captures `sel_code` |
| done | input | 1 | Load complete; parks the output clock low |
| cclk_out | output | 1 | Configuration clock driven to the serial source |
| rise_stb | output | 1 | Sample strobe: first oscillator cycle of a high phase |
| fall_stb | output | 1 | Launch strobe: first oscillator cycle of a low phase |

## Verification
A wrong phase counter or a wrong active divisor appears at the pin as a mismatched high or low width. The bench sees it within one period of the affected rate, at most 64 oscillator cycles at the default. A pending register that swaps too early shows up as a high phase whose length differs from the low phase before it. A wrong stop latch shows up as a runt high phase or as a rising edge after `done`, within the next phase. Strobes that are out of step with the pin show up in the very cycle the pin changes.

// File: rtl/cfgclk_pkg.sv
package cfgclk_pkg;

  // Level of the generated configuration clock.
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } cclk_phase_e;

  // Edge event strobes handed to the serial loader.
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_evt_t;

endpackage

// File: rtl/cfgclk_rst_sync.sv
module cfgclk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/cfgclk_rate_sel.sv
module cfgclk_rate_sel #(
  parameter int unsigned SLOW_HALF = 32,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned CNT_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              sel_load,
  input  logic              period_end,
  output logic [CNT_W-1:0]  half_len
);

  localparam int unsigned NCODES = 2 ** CODE_W;
  localparam logic [CNT_W-1:0] RESET_HALF = CNT_W'(SLOW_HALF);

  logic [CNT_W-1:0] tbl [NCODES];

  // Half-period length per code: SLOW_HALF shifted down, floored at one cycle.
  for (genvar k = 0; k < NCODES; k++) begin : g_tbl
    localparam int unsigned SHIFTED = SLOW_HALF >> k;
    localparam int unsigned HLEN    = (SHIFTED == 0) ? 1 : SHIFTED;
    assign tbl[k] = CNT_W'(HLEN);
  end

  logic [CNT_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] pend_q, pend_d;
  logic             pend_v_q, pend_v_d;

  always_comb begin
    act_d    = act_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    if (period_end && pend_v_q) begin
      act_d    = pend_q;
      pend_v_d = 1'b0;
    end
    if (sel_load) begin
      pend_d   = tbl[sel_code];
      pend_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= RESET_HALF;
      pend_q   <= RESET_HALF;
      pend_v_q <= 1'b0;
    end else begin
      act_q    <= act_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
    end
  end

  assign half_len = act_q;

endmodule

// File: rtl/cfgclk_stop_ctl.sv
module cfgclk_stop_ctl
  import cfgclk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        done,
  input  cclk_phase_e phase,
  output logic        hold
);

  logic done_seen_q, done_seen_d;

  always_comb begin
    done_seen_d = done_seen_q | done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_seen_q <= 1'b0;
    else        done_seen_q <= done_seen_d;
  end

  // Freeze only in the low phase, so a high phase always completes.
  assign hold = (done | done_seen_q) & (phase == PH_LOW);

endmodule

// File: rtl/cfgclk_phase_gen.sv
module cfgclk_phase_gen
  import cfgclk_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] half_len,
  input  logic             hold,
  output cclk_phase_e      phase,
  output edge_evt_t        evt,
  output logic             period_end
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cclk_phase_e      phase_q, phase_d;
  edge_evt_t        evt_q, evt_d;
  logic             wrap;
  logic             advance;

  always_comb begin
    wrap       = (cnt_q == (half_len - CNT_W'(1)));
    advance    = ~hold;
    cnt_d      = cnt_q;
    phase_d    = phase_q;
    evt_d      = '0;
    period_end = 1'b0;
    if (advance) begin
      if (wrap) begin
        cnt_d      = '0;
        phase_d    = (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
        evt_d.rise = (phase_q == PH_LOW);
        evt_d.fall = (phase_q == PH_HIGH);
        period_end = (phase_q == PH_HIGH);
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= PH_LOW;
      evt_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      evt_q   <= evt_d;
    end
  end

  assign phase = phase_q;
  assign evt   = evt_q;

endmodule

// File: rtl/cfgclk_master_gen.sv
module cfgclk_master_gen
  import cfgclk_pkg::*;
#(
  parameter int unsigned SLOW_HALF = 32,
  parameter int unsigned CODE_W    = 4
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              sel_load,
  input  logic              done,
  output logic              cclk_out,
  output logic              rise_stb,
  output logic              fall_stb
);

  localparam int unsigned CNT_W = $clog2(SLOW_HALF + 1);

  logic             srst_n;
  logic [CNT_W-1:0] half_len;
  logic             period_end;
  logic             hold;
  cclk_phase_e      phase;
  edge_evt_t        evt;

  cfgclk_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (osc_clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cfgclk_rate_sel #(
    .SLOW_HALF (SLOW_HALF),
    .CODE_W    (CODE_W),
    .CNT_W     (CNT_W)
  ) u_rate_sel (
    .clk        (osc_clk),
    .rst_n      (srst_n),
    .sel_code   (sel_code),
    .sel_load   (sel_load),
    .period_end (period_end),
    .half_len   (half_len)
  );

  cfgclk_stop_ctl u_stop_ctl (
    .clk   (osc_clk),
    .rst_n (srst_n),
    .done  (done),
    .phase (phase),
    .hold  (hold)
  );

  cfgclk_phase_gen #(.CNT_W(CNT_W)) u_phase_gen (
    .clk        (osc_clk),
    .rst_n      (srst_n),
    .half_len   (half_len),
    .hold       (hold),
    .phase      (phase),
    .evt        (evt),
    .period_end (period_end)
  );

  assign cclk_out = (phase == PH_HIGH);
  assign rise_stb = evt.rise;
  assign fall_stb = evt.fall;

endmodule

// File: rtl/cfgclk_master_gen_chk.sv
module cfgclk_master_gen_chk #(
  parameter int unsigned W = 16
) (
  input logic osc_clk,
  input logic rst_n,
  input logic done,
  input logic cclk_out,
  input logic rise_stb,
  input logic fall_stb
);

  logic [W-1:0] w_q, w_d;
  logic [W-1:0] lw_q, lw_d;
  logic         lw_v_q, lw_v_d;
  logic         seen_fall_q, seen_fall_d;
  logic         done_seen_q, done_seen_d;

  always_comb begin
    w_d         = (rise_stb || fall_stb) ? W'(1) :
                  ((&w_q) ? w_q : w_q + W'(1));
    lw_d        = lw_q;
    lw_v_d      = lw_v_q;
    seen_fall_d = seen_fall_q | fall_stb;
    done_seen_d = done_seen_q | done;
    if (rise_stb) begin
      lw_d   = w_q;
      lw_v_d = seen_fall_q;
    end
  end

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q         <= '0;
      lw_q        <= '0;
      lw_v_q      <= 1'b0;
      seen_fall_q <= 1'b0;
      done_seen_q <= 1'b0;
    end else begin
      w_q         <= w_d;
      lw_q        <= lw_d;
      lw_v_q      <= lw_v_d;
      seen_fall_q <= seen_fall_d;
      done_seen_q <= done_seen_d;
    end
  end

  assert_strobe_excl_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));

  assert_rise_on_edge_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    rise_stb |-> $rose(cclk_out));

  assert_fall_on_edge_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    fall_stb |-> $fell(cclk_out));

  assert_edge_has_strobe_R5: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !$stable(cclk_out) |-> (rise_stb || fall_stb));

  assert_even_period_R3: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (fall_stb && lw_v_q) |-> (w_q == lw_q));

  assert_stop_low_R7: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (done && !cclk_out) |=> !cclk_out);

  assert_parked_R6: assert property (@(posedge osc_clk) disable iff (!rst_n)
    (done_seen_q && !cclk_out) |=> (!cclk_out && !rise_stb));

endmodule

bind cfgclk_master_gen cfgclk_master_gen_chk u_chk (
  .osc_clk  (osc_clk),
  .rst_n    (rst_n),
  .done     (done),
  .cclk_out (cclk_out),
  .rise_stb (rise_stb),
  .fall_stb (fall_stb)
);

// File: tb/cfgclk_master_gen_tb.sv
module cfgclk_master_gen_tb;

  logic       osc_clk;
  logic       rst_n;
  logic [3:0] sel_code;
  logic       sel_load;
  logic       done;
  logic       cclk_out;
  logic       rise_stb;
  logic       fall_stb;

  int n_chk;
  int n_bad;
  bit finished;

  cfgclk_master_gen u_dut (
    .osc_clk  (osc_clk),
    .rst_n    (rst_n),
    .sel_code (sel_code),
    .sel_load (sel_load),
    .done     (done),
    .cclk_out (cclk_out),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  initial osc_clk = 1'b0;
  always #5 osc_clk = ~osc_clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel_load = 1'b0; sel_code = '0; done = 1'b0;
    repeat (4) @(negedge osc_clk);
    rst_n = 1'b1;
    repeat (3) @(negedge osc_clk);
  endtask

  // Count negedges from the current sample until the wanted strobe is seen.
  task automatic span(input bit to_rise, output int n);
    n = 0;
    do begin
      @(negedge osc_clk);
      n++;
    end while (!(to_rise ? rise_stb : fall_stb) && n < 4000);
  endtask

  task automatic load_code(input logic [3:0] c);
    @(negedge osc_clk);
    sel_code = c; sel_load = 1'b1;
    @(negedge osc_clk);
    sel_load = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge osc_clk);
    done = 1'b1;
    @(negedge osc_clk);
    done = 1'b0;
  endtask

  task automatic watch_parked(input string tag, input int cycles);
    int bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge osc_clk);
      if (cclk_out || rise_stb || fall_stb) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic t_reset();
    int n;
    rst_n = 1'b0; sel_load = 1'b0; sel_code = '0; done = 1'b0;
    repeat (3) @(negedge osc_clk);
    chk({cclk_out, rise_stb, fall_stb} == 3'b000, "R1 outputs in reset",
        {cclk_out, rise_stb, fall_stb}, 0);
    rst_n = 1'b1;
    @(negedge osc_clk);
    chk({cclk_out, rise_stb, fall_stb} == 3'b000, "R1 outputs after release",
        {cclk_out, rise_stb, fall_stb}, 0);
    span(1'b1, n);
    span(1'b0, n);
    chk(n == 32, "R1 default high width", n, 32);
    span(1'b1, n);
    chk(n == 32, "R1 default low width", n, 32);
  endtask

  task automatic t_strobes();
    int rises = 0, falls = 0, bad = 0;
    logic prev = cclk_out;
    for (int i = 0; i < 64; i++) begin
      @(negedge osc_clk);
      if (rise_stb) rises++;
      if (fall_stb) falls++;
      if (rise_stb && fall_stb) bad++;
      if (rise_stb && !(cclk_out && !prev)) bad++;
      if (fall_stb && !(!cclk_out && prev)) bad++;
      if ((cclk_out != prev) && !(rise_stb || fall_stb)) bad++;
      prev = cclk_out;
    end
    chk(rises == 1 && falls == 1, "R5 one strobe each per period", rises * 10 + falls, 11);
    chk(bad == 0, "R5 strobe alignment", bad, 0);
  endtask

  // Chained rate changes, each loaded just after a rising edge.
  task automatic t_rates();
    int n;
    int olds [4] = '{32, 16, 8, 4};
    int news [4] = '{16, 8, 4, 2};
    do_reset();
    span(1'b1, n);
    for (int i = 0; i < 4; i++) begin
      load_code(4'(i + 1));
      span(1'b0, n);
      chk(n == olds[i] - 2, "R3 current high keeps old rate", n, olds[i] - 2);
      span(1'b1, n);
      chk(n == news[i], "R2 new low width", n, news[i]);
      span(1'b0, n);
      chk(n == news[i], "R2 new high width", n, news[i]);
      span(1'b1, n);
    end
  endtask

  task automatic t_low_load();
    int n;
    do_reset();
    span(1'b1, n);
    span(1'b0, n);
    load_code(4'd2);
    span(1'b1, n);
    chk(n == 30, "R3 low phase keeps old rate", n, 30);
    span(1'b0, n);
    chk(n == 32, "R3 high phase keeps old rate", n, 32);
    span(1'b1, n);
    chk(n == 8, "R3 switch after fall low", n, 8);
    span(1'b0, n);
    chk(n == 8, "R3 switch after fall high", n, 8);
  endtask

  task automatic t_last_wins();
    int n;
    do_reset();
    span(1'b1, n);
    load_code(4'd1);
    load_code(4'd3);
    span(1'b0, n);
    chk(n == 28, "R4 old high", n, 28);
    span(1'b1, n);
    chk(n == 4, "R4 last code low", n, 4);
    span(1'b0, n);
    chk(n == 4, "R4 last code high", n, 4);
  endtask

  task automatic t_clamp();
    int n, bad = 0;
    logic prev;
    do_reset();
    span(1'b1, n);
    load_code(4'd7);
    span(1'b0, n);
    chk(n == 30, "R2 old high before clamp", n, 30);
    prev = cclk_out;
    for (int i = 0; i < 10; i++) begin
      @(negedge osc_clk);
      if (cclk_out == prev) bad++;
      if (cclk_out && !rise_stb) bad++;
      if (!cclk_out && !fall_stb) bad++;
      prev = cclk_out;
    end
    chk(bad == 0, "R2 code 7 gives one-cycle phases", bad, 0);
  endtask

  task automatic t_reset_mid();
    int n;
    // The clock is running at the clamped fastest rate here.
    rst_n = 1'b0;
    repeat (2) @(negedge osc_clk);
    chk({cclk_out, rise_stb, fall_stb} == 3'b000, "R8 outputs in mid-run reset",
        {cclk_out, rise_stb, fall_stb}, 0);
    rst_n = 1'b1;
    span(1'b1, n);
    span(1'b0, n);
    chk(n == 32, "R8 slow rate after reset", n, 32);
  endtask

  task automatic t_done_high();
    int n;
    do_reset();
    span(1'b1, n);
    pulse_done();
    span(1'b0, n);
    chk(n == 30, "R6 high phase completes", n, 30);
    watch_parked("R6 parked low after done", 200);
  endtask

  task automatic t_done_low();
    int n;
    do_reset();
    span(1'b1, n);
    span(1'b0, n);
    pulse_done();
    watch_parked("R7 no rise after done in low", 200);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    t_reset();
    t_strobes();
    t_rates();
    t_low_load();
    t_last_wins();
    t_clamp();
    t_reset_mid();
    t_done_high();
    t_done_low();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge osc_clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule